// File: doc/BRIEF.md
# ADC result justification register

This block sits between an analog-to-digital converter core and a byte-wide register read port. The core supplies a 10-bit conversion result together with a one-cycle valid strobe. The block keeps that raw result and shows it as two 8-bit bytes, a high byte and a low byte. A 2-bit format field decides where the result bits land in those two bytes.

In three of the four formats a read-order interlock applies. Reading the high byte locks the held result. Reading the low byte releases it. While the result is locked, any new conversion is discarded and a sticky flag records the loss. In the fourth format, 8-bit truncation, the interlock has no effect and every conversion is stored.

The result is kept in raw form and formatted when it is read. Changing the format field therefore shows the held value again in the new layout, with no new conversion needed.

Control is a two-state lock machine with states `LK_OPEN` and `LK_HELD`. It has two transitions:
- **lock**: `LK_OPEN` → `LK_HELD`, taken on a high-byte read while an interlocked format is selected.
- **release**: `LK_HELD` → `LK_OPEN`, taken on any low-byte read.

Top module: `adc_result_fmt`

## Requirements
- R1: The format field `mode_i` is decoded as follows: 2'b00 is left justified, 2'b01 is right justified, 2'b10 is left justified with the top bit inverted, and 2'b11 is 8-bit truncation. `rd_hi_i`=1 selects the high byte and `rd_hi_i`=0 selects the low byte.
- R2: In left-justified format, the high byte holds result bits 9..2. The low byte holds result bits 1..0 in its bits 7..6, and its bits 5..0 read as zero.
- R3: In right-justified format, the high byte holds result bits 9..8 in its bits 1..0, and its bits 7..2 read as zero. The low byte holds result bits 7..0.
- R4: The signed left format uses the same layout as R2, except that bit 7 of the high byte is the complement of result bit 9.
- R5: In truncation format, the low byte holds result bits 9..2 and the high byte reads as zero. Result bits 1..0 are not shown.
- R6: In an interlocked format, a high-byte read locks the held result and any later low-byte read releases it. A valid conversion that arrives while the result is locked is not stored.
- R7: `dropped_o` goes to 1 in the cycle after a conversion is discarded. It stays at 1 until reset.
- R8: After reset, both bytes read as zero, the lock is released and `dropped_o` is 0.
- R9: A change of `mode_i` shows the held result in the new format at once, with no new conversion.
- R10: In truncation format, every valid conversion is stored, and a high-byte read does not set the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid_i | input | 1 | One-cycle strobe that marks a new conversion |
| conv_data_i | input | 10 | Raw conversion result |
| mode_i | input | 2 | Format select (see R1) |
| rd_en_i | input | 1 | Read strobe; a read has its interlock effect at the clock edge |
| rd_hi_i | input | 1 | Byte select: 1 for the high byte, 0 for the low byte |
| rd_data_o | output | 8 | Selected byte in the current format (combinational) |
| dropped_o | output | 1 | Sticky flag for a discarded conversion |

## Verification
The bench holds one raw value and steps through all four formats without a new conversion. A design that latched the formatted bytes at store time would show a stale layout, and a design with a swapped mode decode or a missed bit inversion would produce wrong bytes.

The bench locks the result, sends a conversion, and reads both bytes. A design with no lock would show the new value, and one that never released the lock would refuse the conversion that follows.

The bench also reads the high byte in truncation mode and then changes format. A design whose truncation-mode reads still set the lock would discard the conversion that comes after, and `dropped_o` would then be wrong as well.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        FMT_LEFT  = 2'b00,
        FMT_RIGHT = 2'b01,
        FMT_LSIGN = 2'b10,
        FMT_TRUNC = 2'b11
    } fmt_mode_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

endpackage

// File: rtl/adc_fmt_lock.sv
module adc_fmt_lock
    import adc_fmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fmt_mode_e mode,
    input  logic      conv_valid,
    input  logic      rd_en,
    input  logic      rd_hi,
    output logic      locked,
    output logic      store_en,
    output logic      drop
);

    lock_state_e state_q, state_d;
    logic        interlocked;

    assign interlocked = (mode != FMT_TRUNC);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: lock / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if (rd_en && rd_hi && interlocked) begin
                    state_d = LK_HELD;
                end
            end
            LK_HELD: begin
                if (rd_en && !rd_hi) begin
                    state_d = LK_OPEN;
                end
            end
            default: state_d = LK_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        locked   = 1'b0;
        store_en = 1'b0;
        drop     = 1'b0;
        unique case (state_q)
            LK_OPEN: begin
                store_en = conv_valid;
            end
            LK_HELD: begin
                locked   = 1'b1;
                store_en = conv_valid && !interlocked;
                drop     = conv_valid && interlocked;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/adc_fmt_store.sv
module adc_fmt_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_en,
    input  logic             drop,
    input  logic [RES_W-1:0] conv_data,
    output logic [RES_W-1:0] res_q,
    output logic             dropped_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            dropped_q <= 1'b0;
        end else begin
            if (store_en) begin
                res_q <= conv_data;
            end
            if (drop) begin
                dropped_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_fmt_format.sv
module adc_fmt_format
    import adc_fmt_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  fmt_mode_e         mode,
    input  logic [RES_W-1:0]  res,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] lo_byte
);

    localparam int SPILL = RES_W - BYTE_W;
    localparam int PAD   = BYTE_W - SPILL;

    logic [BYTE_W-1:0] top_bits;
    logic [BYTE_W-1:0] spill_left;
    logic [BYTE_W-1:0] spill_right;
    logic [BYTE_W-1:0] sign_flip;

    assign top_bits    = res[RES_W-1 -: BYTE_W];
    assign spill_left  = {res[SPILL-1:0], {PAD{1'b0}}};
    assign spill_right = {{PAD{1'b0}}, res[RES_W-1 -: SPILL]};
    assign sign_flip   = {1'b1, {(BYTE_W-1){1'b0}}};

    always_comb begin
        unique case (mode)
            FMT_LEFT: begin
                hi_byte = top_bits;
                lo_byte = spill_left;
            end
            FMT_RIGHT: begin
                hi_byte = spill_right;
                lo_byte = res[BYTE_W-1:0];
            end
            FMT_LSIGN: begin
                hi_byte = top_bits ^ sign_flip;
                lo_byte = spill_left;
            end
            FMT_TRUNC: begin
                hi_byte = '0;
                lo_byte = top_bits;
            end
            default: begin
                hi_byte = '0;
                lo_byte = '0;
            end
        endcase
    end

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
    import adc_fmt_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_valid_i,
    input  logic [RES_W-1:0]  conv_data_i,
    input  logic [1:0]        mode_i,
    input  logic              rd_en_i,
    input  logic              rd_hi_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              dropped_o
);

    fmt_mode_e         mode;
    logic              locked;
    logic              store_en;
    logic              drop;
    logic [RES_W-1:0]  res_q;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] lo_byte;

    assign mode = fmt_mode_e'(mode_i);

    adc_fmt_lock u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .conv_valid (conv_valid_i),
        .rd_en      (rd_en_i),
        .rd_hi      (rd_hi_i),
        .locked     (locked),
        .store_en   (store_en),
        .drop       (drop)
    );

    adc_fmt_store #(.RES_W(RES_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_en  (store_en),
        .drop      (drop),
        .conv_data (conv_data_i),
        .res_q     (res_q),
        .dropped_q (dropped_o)
    );

    adc_fmt_format #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_format (
        .mode    (mode),
        .res     (res_q),
        .hi_byte (hi_byte),
        .lo_byte (lo_byte)
    );

    assign rd_data_o = rd_hi_i ? hi_byte : lo_byte;

endmodule

// File: rtl/adc_result_fmt_chk.sv
module adc_result_fmt_chk #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_valid_i,
    input logic [RES_W-1:0]  conv_data_i,
    input logic [1:0]        mode_i,
    input logic              rd_en_i,
    input logic              rd_hi_i,
    input logic              locked,
    input logic [RES_W-1:0]  res_q,
    input logic [BYTE_W-1:0] hi_byte,
    input logic              dropped_o
);

    // R6: a conversion arriving while locked in an interlocked format leaves the held value alone
    a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && conv_valid_i && mode_i != 2'b11) |=> ($stable(res_q) && dropped_o));

    // R6: a low-byte read always releases the lock
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !rd_hi_i) |=> !locked);

    // R6: a high-byte read in an interlocked format sets the lock
    a_r6_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_hi_i && mode_i != 2'b11) |=> locked);

    // R7: the drop flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dropped_o |=> dropped_o);

    // R10: truncation format stores every conversion
    a_r10_trunc_store: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_valid_i && mode_i == 2'b11) |=> (res_q == $past(conv_data_i)));

    // R5: high byte is blank in truncation format
    a_r5_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> (hi_byte == '0));

    // R4: the signed format shows the complement of the result's top bit
    a_r4_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> (hi_byte[BYTE_W-1] == !res_q[RES_W-1]));

endmodule

bind adc_result_fmt adc_result_fmt_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_valid_i (conv_valid_i),
    .conv_data_i  (conv_data_i),
    .mode_i       (mode_i),
    .rd_en_i      (rd_en_i),
    .rd_hi_i      (rd_hi_i),
    .locked       (locked),
    .res_q        (res_q),
    .hi_byte      (hi_byte),
    .dropped_o    (dropped_o)
);

// File: tb/adc_result_fmt_bench.sv
module adc_result_fmt_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_valid_i = 1'b0;
    logic [9:0] conv_data_i = '0;
    logic [1:0] mode_i = 2'b00;
    logic       rd_en_i = 1'b0;
    logic       rd_hi_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       dropped_o;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    adc_result_fmt u_adc_result_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_valid_i (conv_valid_i),
        .conv_data_i  (conv_data_i),
        .mode_i       (mode_i),
        .rd_en_i      (rd_en_i),
        .rd_hi_i      (rd_hi_i),
        .rd_data_o    (rd_data_o),
        .dropped_o    (dropped_o)
    );

    // expected byte from the requirement layouts
    function automatic logic [7:0] expect_byte(input logic [1:0] m, input logic [9:0] r, input logic hi);
        logic [7:0] v;
        case (m)
            2'b00: v = hi ? r[9:2] : {r[1:0], 6'b0};
            2'b01: v = hi ? {6'b0, r[9:8]} : r[7:0];
            2'b10: v = hi ? {~r[9], r[8:2]} : {r[1:0], 6'b0};
            default: v = hi ? 8'h00 : r[9:2];
        endcase
        return v;
    endfunction

    task automatic conv(input logic [9:0] d);
        @(posedge clk); #1;
        conv_valid_i = 1'b1;
        conv_data_i  = d;
        @(posedge clk); #1;
        conv_valid_i = 1'b0;
    endtask

    task automatic rd(input logic hi, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en_i = 1'b1;
        rd_hi_i = hi;
        @(posedge clk); #1;
        rd_en_i = 1'b0;
    endtask

    task automatic check_drop(input logic e, input string tag);
        vectors++;
        if (dropped_o !== e) begin
            miscompares++;
            $display("FAIL %s dropped_o actual=%0b expected=%0b", tag, dropped_o, e);
        end
    endtask

    // monitor: pops expectations as reads occur
    always @(negedge clk) begin
        if (rd_en_i) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (rd_data_o !== e) begin
                miscompares++;
                $display("FAIL %s rd_data actual=%02h expected=%02h", t, rd_data_o, e);
            end
        end
    end

    initial begin
        #(200000 * 20);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [9:0] a;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 reset state
        check_drop(1'b0, "R8");
        rd(1'b1, 8'h00, "R8 hi");
        rd(1'b0, 8'h00, "R8 lo");

        // R3 / R1 right justified
        a = 10'h2A5;
        mode_i = 2'b01;
        conv(a);
        rd(1'b1, expect_byte(2'b01, a, 1'b1), "R3 hi");
        rd(1'b0, expect_byte(2'b01, a, 1'b0), "R3 lo");

        // R9 / R2 reformat held value as left justified
        mode_i = 2'b00;
        rd(1'b1, expect_byte(2'b00, a, 1'b1), "R9 R2 hi");
        rd(1'b0, expect_byte(2'b00, a, 1'b0), "R9 R2 lo");

        // R4 signed
        mode_i = 2'b10;
        rd(1'b1, expect_byte(2'b10, a, 1'b1), "R4 hi");
        rd(1'b0, expect_byte(2'b10, a, 1'b0), "R4 lo");

        // R5 truncation
        mode_i = 2'b11;
        rd(1'b1, 8'h00, "R5 hi");
        rd(1'b0, expect_byte(2'b11, a, 1'b0), "R5 lo");

        // R6 / R7 interlock drops a conversion
        mode_i = 2'b00;
        conv(10'h155);
        rd(1'b1, expect_byte(2'b00, 10'h155, 1'b1), "R6 hi locks");
        check_drop(1'b0, "R7 before drop");
        conv(10'h3FF);
        check_drop(1'b1, "R7 after drop");
        rd(1'b1, expect_byte(2'b00, 10'h155, 1'b1), "R6 held hi");
        rd(1'b0, expect_byte(2'b00, 10'h155, 1'b0), "R6 held lo");
        conv(10'h3FF);
        rd(1'b1, expect_byte(2'b00, 10'h3FF, 1'b1), "R6 after release hi");
        rd(1'b0, expect_byte(2'b00, 10'h3FF, 1'b0), "R6 after release lo");
        check_drop(1'b1, "R7 sticky");

        // R10 truncation ignores the interlock
        mode_i = 2'b11;
        rd(1'b1, 8'h00, "R10 hi no lock");
        conv(10'h0F0);
        rd(1'b0, expect_byte(2'b11, 10'h0F0, 1'b0), "R10 first");
        rd(1'b1, 8'h00, "R10 hi again");
        conv(10'h3FC);
        rd(1'b0, expect_byte(2'b11, 10'h3FC, 1'b0), "R10 second");
        rd(1'b1, 8'h00, "R10 hi before switch");
        mode_i = 2'b00;
        conv(10'h004);
        rd(1'b1, expect_byte(2'b00, 10'h004, 1'b1), "R10 R1 stored after trunc hi read");
        rd(1'b0, expect_byte(2'b00, 10'h004, 1'b0), "R10 R1 lo");

        // R1 decode of right format with a full-scale value
        mode_i = 2'b01;
        conv(10'h3FF);
        rd(1'b0, expect_byte(2'b01, 10'h3FF, 1'b0), "R1 R3 lo");
        rd(1'b1, expect_byte(2'b01, 10'h3FF, 1'b1), "R1 R3 hi");

        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule